// File: doc/BRIEF.md
# Clock-Activity Power-State Controller

This controller chooses the operating state of a four-channel voice codec. The three states are powered down, power saving and running. It runs on a free-running reference clock. It samples three inputs: a level that allows operation, the PCM bit clock, and the transmit frame sync. The bit clock and the frame sync are asynchronous to the reference clock, so each passes through a two-flop synchronizer before any edge is detected.

While operation is allowed and both clocks keep toggling, the block stays in the running state. The PCM data outputs are driven and the analog output stages are released. The block falls back to power saving when either clock stops at any level for longer than its programmable timeout. Pulling the allow level low forces the powered-down state at once, whatever the clocks are doing.

Leaving power saving takes a qualification window of consecutive frame-sync periods with a live bit clock. Each time the block enters the running state, it sends a one-cycle reset to the PCM framing logic.

Top module: `pcm_power_ctl`

## Requirements
- R1: A low `op_enable` (after its two-flop synchronizer) forces state DOWN within three reference cycles, overriding all clock activity.
- R2: A bit clock held static, either at 1 or at 0, for more than `CLK_LOSS` reference cycles moves an ACTIVE controller to SAVE.
- R3: A frame sync held static, either at 1 or at 0, for more than `SYNC_LOSS` reference cycles moves an ACTIVE controller to SAVE.
- R4: The state code is 2'b00 for DOWN, 2'b01 for SAVE and 2'b10 for ACTIVE. ACTIVE is entered only from SAVE, on the third consecutive frame-sync rising edge seen while the bit clock is alive. This spans two whole sync periods.
- R5: `pcm_hiz_o` and `aout_park_o` are 1 in every state except ACTIVE, and 0 in ACTIVE.
- R6: `frame_rst_o` is high for exactly one reference cycle, namely the first cycle of each entry into ACTIVE, and is low at all other times.
- R7: While reset is applied, the state is DOWN, `pcm_hiz_o` and `aout_park_o` are 1, and `frame_rst_o` is 0.
- R8: In DOWN with `op_enable` high, the controller moves to SAVE even when neither clock toggles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_enable | input | 1 | 1 allows operation, 0 requests power-down |
| bit_clk | input | 1 | PCM bit clock, asynchronous to clk |
| tx_sync | input | 1 | Transmit frame sync, asynchronous to clk |
| state_o | output | 2 | Current state: 00 DOWN, 01 SAVE, 10 ACTIVE |
| pcm_hiz_o | output | 1 | 1 puts the PCM data outputs in high impedance |
| aout_park_o | output | 1 | 1 parks the analog outputs at signal ground, high impedance |
| frame_rst_o | output | 1 | One-cycle reset pulse for the PCM framing logic |

## Verification
Every cycle, the embedded assertions check the following:
- a low synchronized enable lands the controller in DOWN;
- a detected clock loss always takes it out of ACTIVE;
- ACTIVE is reached only from SAVE;
- each framing-reset pulse coincides with an entry into ACTIVE;
- the illegal state code never appears.

Some behaviour can only be shown by the bench scenarios, because it depends on real waveforms. These cases are: stopping each clock at each static level, the exact qualification count when the sync restarts, power-down taking priority over running clocks, and the total number of framing-reset pulses over a long run.

// File: rtl/pcm_power_ctl.sv
module pcm_power_ctl #(
  parameter int CLK_LOSS   = 1024,
  parameter int SYNC_LOSS  = 12000,
  parameter int QUAL_EDGES = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       op_enable,
  input  logic       bit_clk,
  input  logic       tx_sync,
  output logic [1:0] state_o,
  output logic       pcm_hiz_o,
  output logic       aout_park_o,
  output logic       frame_rst_o
);
  localparam int CW = $clog2(CLK_LOSS + 1);
  localparam int SW = $clog2(SYNC_LOSS + 1);
  localparam int QW = $clog2(QUAL_EDGES + 1);

  typedef enum logic [1:0] {ST_DOWN = 2'd0, ST_SAVE = 2'd1, ST_ACTIVE = 2'd2} pstate_t;

  pstate_t        st, nxt;
  logic [2:0]     bck_sh, syn_sh;
  logic [1:0]     en_sh;
  logic [CW-1:0]  bck_idle;
  logic [SW-1:0]  syn_idle;
  logic [QW-1:0]  qual;

  wire bck_edge = bck_sh[2] ^ bck_sh[1];
  wire syn_edge = syn_sh[2] ^ syn_sh[1];
  wire syn_rise = syn_sh[1] & ~syn_sh[2];
  wire bck_lost = (bck_idle == CW'(CLK_LOSS));
  wire syn_lost = (syn_idle == SW'(SYNC_LOSS));
  wire en_ok    = en_sh[1];
  wire qual_hit = syn_rise && !bck_lost && (qual == QW'(QUAL_EDGES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bck_sh <= '0;
      syn_sh <= '0;
      en_sh  <= '0;
    end else begin
      bck_sh <= {bck_sh[1:0], bit_clk};
      syn_sh <= {syn_sh[1:0], tx_sync};
      en_sh  <= {en_sh[0], op_enable};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bck_idle <= CW'(CLK_LOSS);
      syn_idle <= SW'(SYNC_LOSS);
    end else begin
      if (bck_edge)       bck_idle <= '0;
      else if (!bck_lost) bck_idle <= bck_idle + 1'b1;
      if (syn_edge)       syn_idle <= '0;
      else if (!syn_lost) syn_idle <= syn_idle + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                 qual <= '0;
    else if (st != ST_SAVE)                     qual <= '0;
    else if (syn_rise && !bck_lost)             qual <= (qual == QW'(QUAL_EDGES)) ? qual : qual + 1'b1;
    else if (bck_lost || syn_lost)              qual <= '0;
  end

  always_comb begin
    nxt = st;
    if (!en_ok) nxt = ST_DOWN;
    else begin
      case (st)
        ST_DOWN:   nxt = ST_SAVE;
        ST_SAVE:   if (qual_hit) nxt = ST_ACTIVE;
        ST_ACTIVE: if (bck_lost || syn_lost) nxt = ST_SAVE;
        default:   nxt = ST_DOWN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= ST_DOWN;
      frame_rst_o <= 1'b0;
    end else begin
      st          <= nxt;
      frame_rst_o <= (nxt == ST_ACTIVE) && (st != ST_ACTIVE);
    end
  end

  assign state_o     = st;
  assign pcm_hiz_o   = (st != ST_ACTIVE);
  assign aout_park_o = (st != ST_ACTIVE);

  a_r1_down_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    !en_ok |=> st == ST_DOWN);
  a_r2_bclk_loss_exits: assert property (@(posedge clk) disable iff (!rst_n)
    (bck_lost && st == ST_ACTIVE) |=> st != ST_ACTIVE);
  a_r3_sync_loss_exits: assert property (@(posedge clk) disable iff (!rst_n)
    (syn_lost && st == ST_ACTIVE) |=> st != ST_ACTIVE);
  a_r4_active_from_save: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_ACTIVE && $past(st) != ST_ACTIVE) |-> $past(st) == ST_SAVE);
  a_r4_legal_code: assert property (@(posedge clk) disable iff (!rst_n)
    state_o != 2'b11);
  a_r6_pulse_on_entry: assert property (@(posedge clk) disable iff (!rst_n)
    frame_rst_o |-> (st == ST_ACTIVE && $past(st) != ST_ACTIVE));
  a_r6_entry_has_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_ACTIVE && $past(st) != ST_ACTIVE) |-> frame_rst_o);
endmodule

// File: tb/tb_pcm_power_ctl.sv
module tb_pcm_power_ctl;
  localparam int NV = 13;
  localparam logic [1:0] DN = 2'd0, SV = 2'd1, AC = 2'd2;
  // {op, bclk_run, sync_run, bclk_level, sync_level, wait[11:0], expected[1:0]}
  localparam logic [18:0] VEC [NV] = '{
    {5'b11100, 12'd1000, AC},
    {5'b10110, 12'd60,   SV},
    {5'b11100, 12'd1000, AC},
    {5'b10100, 12'd60,   SV},
    {5'b11100, 12'd1000, AC},
    {5'b11001, 12'd600,  SV},
    {5'b11100, 12'd1000, AC},
    {5'b11000, 12'd600,  SV},
    {5'b11100, 12'd1000, AC},
    {5'b01100, 12'd20,   DN},
    {5'b10000, 12'd600,  SV},
    {5'b00000, 12'd20,   DN},
    {5'b11100, 12'd1000, AC}
  };

  logic clk = 1'b0, rst_n = 1'b0, op_enable = 1'b0, bit_clk = 1'b0, tx_sync = 1'b0;
  logic [1:0] state_o;
  logic pcm_hiz_o, aout_park_o, frame_rst_o;
  logic brun = 1'b0, srun = 1'b0, blev = 1'b0, slev = 1'b0;
  int nchk = 0, nfail = 0, fr_cnt = 0;

  always #10 clk = ~clk;

  pcm_power_ctl #(.CLK_LOSS(16), .SYNC_LOSS(400), .QUAL_EDGES(3)) dut (
    .clk(clk), .rst_n(rst_n), .op_enable(op_enable), .bit_clk(bit_clk), .tx_sync(tx_sync),
    .state_o(state_o), .pcm_hiz_o(pcm_hiz_o), .aout_park_o(aout_park_o), .frame_rst_o(frame_rst_o));

  initial begin : bclk_gen
    int div = 0;
    forever begin
      @(negedge clk);
      if (brun) begin
        div++;
        if (div == 4) begin bit_clk = ~bit_clk; div = 0; end
      end else begin
        bit_clk = blev; div = 0;
      end
    end
  end

  initial begin : sync_gen
    int ph = 0;
    forever begin
      @(negedge clk);
      if (srun) begin
        tx_sync = (ph < 8);
        ph = (ph == 255) ? 0 : ph + 1;
      end else begin
        tx_sync = slev; ph = 0;
      end
    end
  end

  always @(negedge clk) if (rst_n && frame_rst_o) fr_cnt++;

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_state(input string req, input logic [1:0] exp);
    chk(req, state_o, exp);
    chk({req, " R5 hiz"}, pcm_hiz_o, exp != AC);
    chk({req, " R5 park"}, aout_park_o, exp != AC);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    chk_state("R7 reset state", DN);
    chk("R7 reset frame_rst", frame_rst_o, 0);
    @(negedge clk);
    rst_n = 1'b1;
    fr_cnt = 0;

    for (int i = 0; i < NV; i++) begin
      {op_enable, brun, srun, blev, slev} = VEC[i][18:14];
      repeat (int'(VEC[i][13:2])) @(negedge clk);
      case (i)
        1, 3:    chk_state($sformatf("R2 vec%0d bclk static", i), VEC[i][1:0]);
        5, 7:    chk_state($sformatf("R3 vec%0d sync static", i), VEC[i][1:0]);
        9, 11:   chk_state($sformatf("R1 vec%0d power-down", i), VEC[i][1:0]);
        10:      chk_state($sformatf("R8 vec%0d save without clocks", i), VEC[i][1:0]);
        default: chk_state($sformatf("R4 vec%0d qualify active", i), VEC[i][1:0]);
      endcase
    end
    chk("R6 frame_rst pulse count", fr_cnt, 6);

    // R4: exact qualification count after sync restarts
    rst_n = 1'b0;
    op_enable = 1'b1; brun = 1'b1; srun = 1'b0; slev = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (40) @(negedge clk);
    chk_state("R8 save after enable", SV);
    fr_cnt = 0;
    srun = 1'b1;
    repeat (400) @(negedge clk);
    chk_state("R4 two edges not enough", SV);
    repeat (300) @(negedge clk);
    chk_state("R4 third edge enters active", AC);
    chk("R6 single pulse on entry", fr_cnt, 1);

    // R1: power-down takes priority while clocks run
    op_enable = 1'b0;
    repeat (4) @(negedge clk);
    chk_state("R1 priority over clocks", DN);
    chk("R6 no pulse on exit", fr_cnt, 1);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule